// File: doc/BRIEF.md
# Freezable BCD Time-of-Day Counter

This block keeps calendar time (hundredths, seconds, minutes, hours, weekday, date, month and year) as packed BCD. It advances on a 100 Hz tick enable. It holds two copies of the time. The internal copy always counts while the oscillator is enabled. The bus-visible copy is refreshed from the internal one on every tick. A command bit lets software freeze the visible copy so that it can read or write a consistent snapshot, and no time is lost while it is frozen.

Carries into seconds and the higher fields are computed on the tick that takes hundredths to 99. They become visible only on the tick that rolls hundredths from 99 to 00. Hours can count in 24-hour form or in 12-hour form with a PM flag. Dates roll over using real month lengths, and every year divisible by four is a leap year. The month register also holds an oscillator stop bit and a square-wave enable. The square-wave output runs at 1024 Hz, derived by dividing a 32.768 kHz enable input by 32.

Top module: `tod_clock`

## Requirements
- R1: After reset the registers read: hundredths, seconds, minutes, hours and year 0x00; weekday 0x01; date 0x01; month register 0xC1 (oscillator stopped, square wave off, January); command register 0x80 (transfer on). `sqw_oe` is 0.
- R2: With the oscillator on and transfer on, each `tick_100` pulse advances hundredths (address 0x0) by one in BCD, and the new value reads back in the next cycle. 99 wraps to 00.
- R3: In 24-hour form (hours bit 6 = 0, bits 5:0 BCD 00–23), 23:59:59.99 advances to 00:00:00.00. The same tick advances the weekday (address 0x6, 7 wraps to 1) and the date (address 0x8).
- R4: In 12-hour form (hours bit 6 = 1, bit 5 = PM, bits 4:0 BCD 01–12), hours count 12, 1, …, 11. Going from 11 to 12 toggles PM. Going from 11 PM to 12 AM advances the date.
- R5: The date wraps to 01 after the last day of the month: 30 days for months 04, 06, 09, 11; 28 for 02, or 29 when the BCD year (address 0xA) is divisible by 4; 31 otherwise. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R6: Writing command bit 7 = 0 (address 0xB) freezes the visible registers while the internal copy keeps counting. After writing bit 7 = 1 without any intervening time write, the next tick shows the full elapsed time.
- R7: A time register written while frozen reads back the written value at once. When transfer is set back to 1, the internal copy is loaded from the visible copy, and counting continues from the written values.
- R8: On the tick that takes hundredths to 99, the visible seconds and higher fields keep their old values. On the 99→00 tick, the whole visible copy equals the internal copy.
- R9: Month register bit 7 = 1 stops counting: `tick_100` pulses then change nothing, internal or visible.
- R10: Month register bit 6 = 0 drives `sqw_oe` to 1, and bit 6 = 1 drives it to 0. While the oscillator runs, `sqw_out` toggles on every 16th `tick_32k` pulse. While the oscillator is stopped, `sqw_out` holds its value.
- R11: Bits with no field read 0: seconds/minutes/hours bit 7, weekday bits 7:3, date bits 7:6, month bit 5, command bits 6:0. Addresses 0x3, 0x5, 0x7 and 0xC–0xF read 0x00, and writes to them change nothing.
- R12: A time register written while transfer is on reads back the written value and also sets the internal copy, so counting continues from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100 | input | 1 | One-cycle 100 Hz count enable |
| tick_32k | input | 1 | One-cycle 32.768 kHz enable for the square wave |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data from the visible copy (combinational) |
| sqw_out | output | 1 | 1024 Hz square wave |
| sqw_oe | output | 1 | Output enable for `sqw_out` |

## Verification
The hardest situation to reach is a frozen visible copy while the internal copy crosses a second boundary, followed by a resume with or without pending writes. Reaching it by ticking alone would take thousands of cycles. The stimulus therefore presets the time just below each boundary (hundredths 98, seconds 59, and so on) through direct writes, then applies only two ticks. For the freeze cases, it runs 150 ticks while frozen and checks that one tick after resuming exposes exactly 1.51 s of elapsed time.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] day;
    logic [6:0] hr;
    logic [6:0] min;
    logic [6:0] sec;
    logic [7:0] hund;
  } tod_t;

  localparam logic [3:0] ADDR_HUND  = 4'h0;
  localparam logic [3:0] ADDR_SEC   = 4'h1;
  localparam logic [3:0] ADDR_MIN   = 4'h2;
  localparam logic [3:0] ADDR_HOUR  = 4'h4;
  localparam logic [3:0] ADDR_DAY   = 4'h6;
  localparam logic [3:0] ADDR_DATE  = 4'h8;
  localparam logic [3:0] ADDR_MONTH = 4'h9;
  localparam logic [3:0] ADDR_YEAR  = 4'hA;
  localparam logic [3:0] ADDR_CMD   = 4'hB;

  localparam tod_t TOD_RESET = '{yr: 8'h00, mon: 5'h01, date: 6'h01, day: 3'd1,
                                 hr: 7'h00, min: 7'h00, sec: 7'h00, hund: 8'h00};

  // BCD increments per field width (no wrap handling; callers decide wrap)
  function automatic logic [7:0] inc8(input logic [7:0] v);
    inc8 = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'h0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] inc7(input logic [6:0] v);
    inc7 = (v[3:0] == 4'd9) ? {v[6:4] + 3'd1, 4'h0} : {v[6:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [5:0] inc6(input logic [5:0] v);
    inc6 = (v[3:0] == 4'd9) ? {v[5:4] + 2'd1, 4'h0} : {v[5:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [4:0] inc5(input logic [4:0] v);
    inc5 = (v[3:0] == 4'd9) ? 5'h10 : {v[4], v[3:0] + 4'd1};
  endfunction

  // Leap test on a two-digit BCD year: value mod 4 == 0
  function automatic logic is_leap(input logic [7:0] yr);
    if (yr[4] == 1'b0)
      is_leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else
      is_leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  // Last date of a month, BCD
  function automatic logic [5:0] last_date(input logic [4:0] mon, input logic [7:0] yr);
    case (mon)
      5'h02:                      last_date = is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_date = 6'h30;
      default:                    last_date = 6'h31;
    endcase
  endfunction

  // One hour step; result bit 7 is the carry into the day
  function automatic logic [7:0] hour_step(input logic [6:0] h);
    if (h[6]) begin
      if (h[4:0] == 5'h12)      hour_step = {1'b0, h[6:5], 5'h01};
      else if (h[4:0] == 5'h11) hour_step = {h[5], h[6], ~h[5], 5'h12};
      else                      hour_step = {1'b0, h[6:5], inc5(h[4:0])};
    end else begin
      if (h[5:0] == 6'h23)      hour_step = 8'h80;
      else                      hour_step = {2'b00, inc6(h[5:0])};
    end
  endfunction

  function automatic logic is_time_addr(input logic [3:0] a);
    is_time_addr = (a == ADDR_HUND) || (a == ADDR_SEC) || (a == ADDR_MIN) ||
                   (a == ADDR_HOUR) || (a == ADDR_DAY) || (a == ADDR_DATE) ||
                   (a == ADDR_MONTH) || (a == ADDR_YEAR);
  endfunction

  // Place one bus write into a time image
  function automatic tod_t put_field(input tod_t t, input logic [3:0] a, input logic [7:0] d);
    tod_t r;
    r = t;
    case (a)
      ADDR_HUND:  r.hund = d;
      ADDR_SEC:   r.sec  = d[6:0];
      ADDR_MIN:   r.min  = d[6:0];
      ADDR_HOUR:  r.hr   = d[6:0];
      ADDR_DAY:   r.day  = d[2:0];
      ADDR_DATE:  r.date = d[5:0];
      ADDR_MONTH: r.mon  = d[4:0];
      ADDR_YEAR:  r.yr   = d;
      default:    r = t;
    endcase
    put_field = r;
  endfunction

endpackage

// File: rtl/tod_advance.sv
// Carry chain from seconds up to years; hundredths pass through untouched.
module tod_advance
  import tod_pkg::*;
(
  input  tod_t cur,
  output tod_t nxt
);
  logic       sec_wrap, min_wrap, day_carry, date_wrap, mon_wrap;
  logic [7:0] hs;

  always_comb begin
    hs        = hour_step(cur.hr);
    sec_wrap  = (cur.sec == 7'h59);
    min_wrap  = sec_wrap && (cur.min == 7'h59);
    day_carry = min_wrap && hs[7];
    date_wrap = day_carry && (cur.date == last_date(cur.mon, cur.yr));
    mon_wrap  = date_wrap && (cur.mon == 5'h12);

    nxt      = cur;
    nxt.sec  = sec_wrap ? 7'h00 : inc7(cur.sec);
    if (sec_wrap)  nxt.min  = min_wrap ? 7'h00 : inc7(cur.min);
    if (min_wrap)  nxt.hr   = hs[6:0];
    if (day_carry) begin
      nxt.day  = (cur.day == 3'd7) ? 3'd1 : cur.day + 3'd1;
      nxt.date = date_wrap ? 6'h01 : inc6(cur.date);
    end
    if (date_wrap) nxt.mon  = mon_wrap ? 5'h01 : inc5(cur.mon);
    if (mon_wrap)  nxt.yr   = (cur.yr == 8'h99) ? 8'h00 : inc8(cur.yr);
  end
endmodule

// File: rtl/tod_sqw_div.sv
module tod_sqw_div #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sq
);
  localparam int HALF = DIV / 2;

  generate
    if (HALF <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (!rst_n)  sq <= 1'b0;
        else if (en) sq <= ~sq;
      end
    end else begin : g_count
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt <= '0;
          sq  <= 1'b0;
        end else if (en) begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            sq  <= ~sq;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tod_rd_mux.sv
module tod_rd_mux
  import tod_pkg::*;
(
  input  logic [3:0] addr,
  input  tod_t       vis,
  input  logic       te,
  input  logic       osc_off,
  input  logic       sqw_off,
  output logic [7:0] rdata
);
  always_comb begin
    case (addr)
      ADDR_HUND:  rdata = vis.hund;
      ADDR_SEC:   rdata = {1'b0, vis.sec};
      ADDR_MIN:   rdata = {1'b0, vis.min};
      ADDR_HOUR:  rdata = {1'b0, vis.hr};
      ADDR_DAY:   rdata = {5'b0, vis.day};
      ADDR_DATE:  rdata = {2'b0, vis.date};
      ADDR_MONTH: rdata = {osc_off, sqw_off, 1'b0, vis.mon};
      ADDR_YEAR:  rdata = vis.yr;
      ADDR_CMD:   rdata = {te, 7'b0};
      default:    rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int SQW_DIV = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_100,
  input  logic       tick_32k,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       sqw_out,
  output logic       sqw_oe
);
  tod_t int_q, ext_q, int_n, ext_n, adv;
  logic te_q, osc_off_q, sqw_off_q, dirty_q, dirty_n;

  // Named events
  logic step_evt, into99_evt, roll_evt, wr_time, wr_cmd, wr_ctl, load_evt;

  assign step_evt   = tick_100 && !osc_off_q;
  assign into99_evt = step_evt && (int_q.hund == 8'h98);
  assign roll_evt   = step_evt && (int_q.hund == 8'h99);
  assign wr_time    = wr_en && is_time_addr(addr);
  assign wr_cmd     = wr_en && (addr == ADDR_CMD);
  assign wr_ctl     = wr_en && (addr == ADDR_MONTH);
  assign load_evt   = wr_cmd && !te_q && wdata[7] && dirty_q;

  tod_advance u_adv (
    .cur (int_q),
    .nxt (adv)
  );

  always_comb begin
    int_n   = int_q;
    ext_n   = ext_q;
    dirty_n = dirty_q;

    if (step_evt) begin
      if (into99_evt) int_n = adv;
      int_n.hund = roll_evt ? 8'h00 : inc8(int_q.hund);
      if (te_q) begin
        if (int_n.hund != 8'h99) ext_n = int_n;
        else                     ext_n.hund = int_n.hund;
      end
    end

    if (wr_time) begin
      ext_n = put_field(ext_n, addr, wdata);
      if (te_q) int_n = put_field(int_n, addr, wdata);
      else      dirty_n = 1'b1;
    end

    if (wr_cmd && wdata[7]) dirty_n = 1'b0;
    if (load_evt) int_n = ext_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q     <= TOD_RESET;
      ext_q     <= TOD_RESET;
      te_q      <= 1'b1;
      osc_off_q <= 1'b1;
      sqw_off_q <= 1'b1;
      dirty_q   <= 1'b0;
    end else begin
      int_q   <= int_n;
      ext_q   <= ext_n;
      dirty_q <= dirty_n;
      if (wr_cmd) te_q <= wdata[7];
      if (wr_ctl) begin
        osc_off_q <= wdata[7];
        sqw_off_q <= wdata[6];
      end
    end
  end

  tod_sqw_div #(.DIV(SQW_DIV)) u_sqw (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (tick_32k && !osc_off_q),
    .sq    (sqw_out)
  );

  assign sqw_oe = !sqw_off_q;

  tod_rd_mux u_rd (
    .addr    (addr),
    .vis     (ext_q),
    .te      (te_q),
    .osc_off (osc_off_q),
    .sqw_off (sqw_off_q),
    .rdata   (rdata)
  );
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
  import tod_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic step,
  input logic roll,
  input logic te_q,
  input logic osc_off,
  input tod_t int_q,
  input tod_t ext_q,
  input logic sqw_out
);
  p_frozen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!te_q && !wr_en) |=> $stable(ext_q));

  p_stopped_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_off && !wr_en) |=> $stable(int_q));

  p_hund_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && !wr_en) |=> (int_q.hund == 8'h00));

  p_resync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && te_q && !wr_en) |=> (ext_q == int_q));

  p_upper_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && te_q && !wr_en && int_q.hund == 8'h98) |=> $stable(ext_q.sec));

  p_sqw_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off |=> $stable(sqw_out));
endmodule

bind tod_clock tod_clock_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .step    (step_evt),
  .roll    (roll_evt),
  .te_q    (te_q),
  .osc_off (osc_off_q),
  .int_q   (int_q),
  .ext_q   (ext_q),
  .sqw_out (sqw_out)
);

// File: tb/tb_tod_clock.sv
module tb_tod_clock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_100 = 1'b0;
  logic       tick_32k = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sqw_out, sqw_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tod_clock dut (
    .clk(clk), .rst_n(rst_n), .tick_100(tick_100), .tick_32k(tick_32k),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .sqw_out(sqw_out), .sqw_oe(sqw_oe)
  );

  task automatic expect8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    expect8(rdata, exp, tag);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_100 = 1'b1;
      @(negedge clk); tick_100 = 1'b0;
    end
  endtask

  task automatic pulse32(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_32k = 1'b1;
      @(negedge clk); tick_32k = 1'b0;
    end
  endtask

  // Preset a time just before a rollover (hundredths 98), month keeps osc on, sqw off
  task automatic preset(input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se,
                        input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr);
    wr(4'h4, hr); wr(4'h2, mi); wr(4'h1, se);
    wr(4'h8, dt); wr(4'h9, 8'h40 | mo); wr(4'hA, yr);
    wr(4'h0, 8'h98);
  endtask

  task automatic t_reset;
    rd(4'h0, 8'h00, "R1 hund");
    rd(4'h1, 8'h00, "R1 sec");
    rd(4'h4, 8'h00, "R1 hour");
    rd(4'h6, 8'h01, "R1 day");
    rd(4'h8, 8'h01, "R1 date");
    rd(4'h9, 8'hC1, "R1 month");
    rd(4'hA, 8'h00, "R1 year");
    rd(4'hB, 8'h80, "R1 cmd");
    expect8({7'b0, sqw_oe}, 8'h00, "R1 sqw_oe");
  endtask

  task automatic t_count;
    wr(4'h9, 8'h41);
    tick(5);
    rd(4'h0, 8'h05, "R2 hund 5");
    tick(7);
    rd(4'h0, 8'h12, "R2 hund bcd 12");
  endtask

  task automatic t_day24;
    preset(8'h23, 8'h59, 8'h59, 8'h01, 8'h01, 8'h00);
    rd(4'h1, 8'h59, "R12 direct write");
    tick(1);
    rd(4'h0, 8'h99, "R8 hund 99");
    rd(4'h1, 8'h59, "R8 sec held at 99");
    rd(4'h4, 8'h23, "R8 hour held at 99");
    tick(1);
    rd(4'h0, 8'h00, "R2 hund wrap");
    rd(4'h1, 8'h00, "R3 sec");
    rd(4'h2, 8'h00, "R3 min");
    rd(4'h4, 8'h00, "R3 hour");
    rd(4'h6, 8'h02, "R3 weekday");
    rd(4'h8, 8'h02, "R3 date");
  endtask

  task automatic t_twelve;
    preset(8'h51, 8'h59, 8'h59, 8'h10, 8'h05, 8'h30);
    tick(2);
    rd(4'h4, 8'h72, "R4 11AM to 12PM");
    rd(4'h8, 8'h10, "R4 date kept at noon");
    preset(8'h72, 8'h59, 8'h59, 8'h10, 8'h05, 8'h30);
    tick(2);
    rd(4'h4, 8'h61, "R4 12PM to 1PM");
    preset(8'h71, 8'h59, 8'h59, 8'h10, 8'h05, 8'h30);
    tick(2);
    rd(4'h4, 8'h52, "R4 11PM to 12AM");
    rd(4'h8, 8'h11, "R4 date at midnight");
  endtask

  task automatic t_calendar;
    preset(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h23);
    tick(2);
    rd(4'h8, 8'h01, "R5 feb28 common date");
    rd(4'h9, 8'h43, "R5 feb28 common month");
    preset(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h24);
    tick(2);
    rd(4'h8, 8'h29, "R5 leap feb29");
    wr(4'h0, 8'h98);
    wr(4'h4, 8'h23); wr(4'h2, 8'h59); wr(4'h1, 8'h59);
    tick(2);
    rd(4'h8, 8'h01, "R5 leap mar1 date");
    rd(4'h9, 8'h43, "R5 leap mar1 month");
    preset(8'h23, 8'h59, 8'h59, 8'h30, 8'h04, 8'h24);
    tick(2);
    rd(4'h9, 8'h45, "R5 apr30 month");
    preset(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99);
    tick(2);
    rd(4'h8, 8'h01, "R5 newyear date");
    rd(4'h9, 8'h41, "R5 newyear month");
    rd(4'hA, 8'h00, "R5 year 99 wrap");
  endtask

  task automatic t_freeze;
    wr(4'h2, 8'h05); wr(4'h1, 8'h10); wr(4'h0, 8'h00);
    wr(4'hB, 8'h00);
    rd(4'hB, 8'h00, "R6 cmd reads 0");
    tick(150);
    rd(4'h0, 8'h00, "R6 frozen hund");
    rd(4'h1, 8'h10, "R6 frozen sec");
    wr(4'hB, 8'h80);
    tick(1);
    rd(4'h0, 8'h51, "R6 resumed hund");
    rd(4'h1, 8'h11, "R6 resumed sec");
    rd(4'h2, 8'h05, "R6 resumed min");
  endtask

  task automatic t_frozen_write;
    wr(4'hB, 8'h00);
    wr(4'h1, 8'h30); wr(4'h0, 8'h00);
    rd(4'h1, 8'h30, "R7 readback while frozen");
    tick(5);
    rd(4'h0, 8'h00, "R7 hund held");
    wr(4'hB, 8'h80);
    tick(3);
    rd(4'h0, 8'h03, "R7 hund from written");
    rd(4'h1, 8'h30, "R7 sec from written");
  endtask

  task automatic t_osc_stop;
    wr(4'h0, 8'h40);
    wr(4'h9, 8'hC1);
    tick(10);
    rd(4'h0, 8'h40, "R9 stopped hund");
    wr(4'h9, 8'h41);
    tick(1);
    rd(4'h0, 8'h41, "R9 restarted");
  endtask

  task automatic t_sqw;
    wr(4'h9, 8'h01);
    expect8({7'b0, sqw_oe}, 8'h01, "R10 oe on");
    pulse32(15);
    expect8({7'b0, sqw_out}, 8'h00, "R10 before 16th");
    pulse32(1);
    expect8({7'b0, sqw_out}, 8'h01, "R10 at 16th");
    wr(4'h9, 8'h81);
    pulse32(20);
    expect8({7'b0, sqw_out}, 8'h01, "R10 held when stopped");
    wr(4'h9, 8'h41);
    expect8({7'b0, sqw_oe}, 8'h00, "R10 oe off");
  endtask

  task automatic t_unused;
    wr(4'hB, 8'h00);
    wr(4'h1, 8'hFF); rd(4'h1, 8'h7F, "R11 sec bit7");
    wr(4'h6, 8'hFF); rd(4'h6, 8'h07, "R11 weekday");
    wr(4'h8, 8'hFF); rd(4'h8, 8'h3F, "R11 date");
    wr(4'h9, 8'h7F); rd(4'h9, 8'h5F, "R11 month bit5");
    wr(4'h5, 8'hFF); rd(4'h5, 8'h00, "R11 addr 5");
    wr(4'hC, 8'hFF); rd(4'hC, 8'h00, "R11 addr C");
    rd(4'h3, 8'h00, "R11 addr 3");
    rd(4'h0, 8'h41, "R11 hund untouched");
    wr(4'h1, 8'h00); wr(4'h6, 8'h03); wr(4'h8, 8'h15); wr(4'h9, 8'h41);
    wr(4'hB, 8'hFF);
    rd(4'hB, 8'h80, "R11 cmd low bits");
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_count;
    t_day24;
    t_twelve;
    t_calendar;
    t_freeze;
    t_frozen_write;
    t_osc_stop;
    t_sqw;
    t_unused;
    repeat (2) @(negedge clk);
    finish_run;
  end

  initial begin
    #(4_000_000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule